// File: doc/BRIEF.md
# Two-Port Hardware Semaphore Bank

This block holds a small set of binary ownership tokens that two independent agents, a left side and a right side, use to coordinate access to a shared resource. Each side has its own semaphore select, output enable, write strobe, address and data bus. A side takes a token by writing a zero to it and gives it back by writing a one. A read returns, on every data bit, whether this side currently holds that token. The bank is kept apart from any data storage. All activity is synchronous to one clock.

Each side has its own request latch for each token. When a side asks for a token that the other side already holds, the request is not lost. It waits in the latch, and the token moves over in the same clock edge at which the holder lets go. When both sides ask for a free token in the same cycle, exactly one of them wins. A parameter picks the rule: left always wins, or the winner alternates from one tie to the next. A request made in an earlier cycle always beats a later one. A read value is frozen for the whole read cycle, so software sees a consistent answer. The request latches are cleared on reset. Software is still expected to write a one to every token from both sides before use.

Top module: `sem_bank2p`

## Requirements
- R1: There are NUM_FLAGS tokens (8 by default). Address bits [2:0] pick the token and every higher address bit is ignored.
- R2: A read returns one bit replicated onto all DATA_W data bits. All zeros means this side holds the token; all ones means it does not.
- R3: A write uses only wdata[0]: 0 requests the token and 1 releases it or withdraws a request. All other data bits are ignored.
- R4: A request on a free token grants it to the requester at the next clock edge. The holder keeps it until it writes 1 itself, and no write from the other side can take it away.
- R5: A zero written by the side that does not hold the token stays pending. When the holder writes 1, the token passes to the waiting side at that same edge.
- R6: A one written by a side that is only waiting withdraws its request, so a later release by the holder leaves the token free.
- R7: When both sides request a free token in the same cycle, exactly one wins. TIE_MODE=0 always gives it to left. TIE_MODE=1 alternates, starting with left after reset, and the shared tie bit toggles once for each cycle that has at least one tie. A request made in an earlier cycle wins over one made in a later cycle.
- R8: rdata is registered. It is captured at the first edge at which both sem_n and oe_n are low, from the state before that edge, and then held while both stay low, even if ownership changes meanwhile.
- R9: In any cycle in which sem_n or oe_n is high, rdata is all ones after the next edge.
- R10: Synchronous active-high reset makes every token free, clears all pending requests, points the tie bit to left and sets both rdata buses to all ones.
- R11: A write takes effect only when sem_n and wr_n are both low. With sem_n high, a low wr_n changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| l_sem_n | input | 1 | Left semaphore select, active low |
| l_oe_n | input | 1 | Left read enable, active low |
| l_wr_n | input | 1 | Left write strobe, active low |
| l_addr | input | ADDR_W | Left address; low bits pick the token |
| l_wdata | input | DATA_W | Left write data; bit 0 used |
| l_rdata | output | DATA_W | Left registered read data |
| r_sem_n | input | 1 | Right semaphore select, active low |
| r_oe_n | input | 1 | Right read enable, active low |
| r_wr_n | input | 1 | Right write strobe, active low |
| r_addr | input | ADDR_W | Right address; low bits pick the token |
| r_wdata | input | DATA_W | Right write data; bit 0 used |
| r_rdata | output | DATA_W | Right registered read data |

## Verification
The bench builds two copies with the default sizes (8 tokens, 16-bit address, 18-bit data), one with TIE_MODE=1 and one with TIE_MODE=0, and drives both with the same stimulus. This makes both tie rules visible in the same cycles: same-cycle requests must give a different winner on the second tie and the same winner on the first. Directed sequences visit every token through varied upper address bits, and cover pending hand-off, withdrawal and a read held across an ownership change. A long pseudo-random run then drives both sides with overlapping requests, releases and reads, and checks both read buses every cycle against an arithmetic model of the token states.

// File: rtl/sem_bank_pkg.sv
package sem_bank_pkg;

  typedef enum logic [1:0] {
    OWN_NONE  = 2'b00,
    OWN_LEFT  = 2'b01,
    OWN_RIGHT = 2'b10
  } owner_e;

  localparam int TIE_FIXED_LEFT = 0;
  localparam int TIE_ALTERNATE  = 1;

endpackage

// File: rtl/sem_port_dec.sv
module sem_port_dec #(
  parameter int ADDR_W    = 16,
  parameter int NUM_FLAGS = 8,
  localparam int SEL_W    = $clog2(NUM_FLAGS)
) (
  input  logic                 sem_n,
  input  logic                 oe_n,
  input  logic                 wr_n,
  input  logic [ADDR_W-1:0]    addr,
  output logic [NUM_FLAGS-1:0] wr_vec,
  output logic                 rd_act,
  output logic [SEL_W-1:0]     idx
);

  logic wr_act;

  assign idx    = addr[SEL_W-1:0];
  assign wr_act = ~sem_n & ~wr_n;
  assign rd_act = ~sem_n & ~oe_n;

  for (genvar f = 0; f < NUM_FLAGS; f++) begin : g_wr
    assign wr_vec[f] = wr_act && (idx == SEL_W'(f));
  end

  if (ADDR_W > SEL_W) begin : g_hi
    logic unused_hi;
    assign unused_hi = ^addr[ADDR_W-1:SEL_W];
  end

endmodule

// File: rtl/sem_flag_cell.sv
module sem_flag_cell
  import sem_bank_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic wr_l,
  input  logic bit_l,
  input  logic wr_r,
  input  logic bit_r,
  input  logic pick_right,
  output logic own_l,
  output logic own_r,
  output logic req_l,
  output logic req_r,
  output logic tie_hit
);

  owner_e own_q, own_d;
  logic   req_l_q, req_r_q;
  logic   nxt_l, nxt_r;

  always_comb begin
    nxt_l   = wr_l ? bit_l : req_l_q;
    nxt_r   = wr_r ? bit_r : req_r_q;
    own_d   = own_q;
    tie_hit = 1'b0;
    unique case (own_q)
      OWN_NONE: begin
        if (!nxt_l && !nxt_r) begin
          tie_hit = 1'b1;
          own_d   = pick_right ? OWN_RIGHT : OWN_LEFT;
        end else if (!nxt_l) begin
          own_d = OWN_LEFT;
        end else if (!nxt_r) begin
          own_d = OWN_RIGHT;
        end
      end
      OWN_LEFT: begin
        if (nxt_l) own_d = nxt_r ? OWN_NONE : OWN_RIGHT;
      end
      OWN_RIGHT: begin
        if (nxt_r) own_d = nxt_l ? OWN_NONE : OWN_LEFT;
      end
      default: own_d = OWN_NONE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_l_q <= 1'b1;
      req_r_q <= 1'b1;
      own_q   <= OWN_NONE;
    end else begin
      req_l_q <= nxt_l;
      req_r_q <= nxt_r;
      own_q   <= own_d;
    end
  end

  assign own_l = (own_q == OWN_LEFT);
  assign own_r = (own_q == OWN_RIGHT);
  assign req_l = req_l_q;
  assign req_r = req_r_q;

endmodule

// File: rtl/sem_read_hold.sv
module sem_read_hold #(
  parameter int DATA_W    = 18,
  parameter int NUM_FLAGS = 8,
  localparam int SEL_W    = $clog2(NUM_FLAGS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rd_act,
  input  logic [SEL_W-1:0]     idx,
  input  logic [NUM_FLAGS-1:0] held_vec,
  output logic [DATA_W-1:0]    rdata
);

  logic act_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q <= 1'b0;
      rdata <= '1;
    end else begin
      act_q <= rd_act;
      if (!rd_act)     rdata <= '1;
      else if (!act_q) rdata <= {DATA_W{~held_vec[idx]}};
    end
  end

endmodule

// File: rtl/sem_bank2p.sv
module sem_bank2p
  import sem_bank_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 18,
  parameter int NUM_FLAGS = 8,
  parameter int TIE_MODE  = TIE_ALTERNATE
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              l_sem_n,
  input  logic              l_oe_n,
  input  logic              l_wr_n,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_rdata,
  input  logic              r_sem_n,
  input  logic              r_oe_n,
  input  logic              r_wr_n,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_rdata
);

  localparam int SEL_W = $clog2(NUM_FLAGS);

  logic [NUM_FLAGS-1:0] lwr_vec, rwr_vec;
  logic [NUM_FLAGS-1:0] own_l_vec, own_r_vec;
  logic [NUM_FLAGS-1:0] req_l_vec, req_r_vec;
  logic [NUM_FLAGS-1:0] tie_vec;
  logic                 l_rd, r_rd;
  logic [SEL_W-1:0]     l_idx, r_idx;
  logic                 pick_right;

  sem_port_dec #(.ADDR_W(ADDR_W), .NUM_FLAGS(NUM_FLAGS)) u_dec_l (
    .sem_n(l_sem_n), .oe_n(l_oe_n), .wr_n(l_wr_n), .addr(l_addr),
    .wr_vec(lwr_vec), .rd_act(l_rd), .idx(l_idx)
  );

  sem_port_dec #(.ADDR_W(ADDR_W), .NUM_FLAGS(NUM_FLAGS)) u_dec_r (
    .sem_n(r_sem_n), .oe_n(r_oe_n), .wr_n(r_wr_n), .addr(r_addr),
    .wr_vec(rwr_vec), .rd_act(r_rd), .idx(r_idx)
  );

  for (genvar f = 0; f < NUM_FLAGS; f++) begin : g_flag
    sem_flag_cell u_cell (
      .clk(clk), .rst(rst),
      .wr_l(lwr_vec[f]), .bit_l(l_wdata[0]),
      .wr_r(rwr_vec[f]), .bit_r(r_wdata[0]),
      .pick_right(pick_right),
      .own_l(own_l_vec[f]), .own_r(own_r_vec[f]),
      .req_l(req_l_vec[f]), .req_r(req_r_vec[f]),
      .tie_hit(tie_vec[f])
    );
  end

  if (TIE_MODE == TIE_ALTERNATE) begin : g_tie_alt
    logic tie_q;
    always_ff @(posedge clk) begin
      if (rst)           tie_q <= 1'b0;
      else if (|tie_vec) tie_q <= ~tie_q;
    end
    assign pick_right = tie_q;
  end else begin : g_tie_fixed
    logic unused_tie;
    assign unused_tie = |tie_vec;
    assign pick_right = 1'b0;
  end

  sem_read_hold #(.DATA_W(DATA_W), .NUM_FLAGS(NUM_FLAGS)) u_rd_l (
    .clk(clk), .rst(rst), .rd_act(l_rd), .idx(l_idx),
    .held_vec(own_l_vec), .rdata(l_rdata)
  );

  sem_read_hold #(.DATA_W(DATA_W), .NUM_FLAGS(NUM_FLAGS)) u_rd_r (
    .clk(clk), .rst(rst), .rd_act(r_rd), .idx(r_idx),
    .held_vec(own_r_vec), .rdata(r_rdata)
  );

  logic unused_wd;
  assign unused_wd = ^{l_wdata[DATA_W-1:1], r_wdata[DATA_W-1:1]};

endmodule

// File: rtl/sem_bank2p_chk.sv
module sem_bank2p_chk #(
  parameter int NUM_FLAGS = 8,
  parameter int DATA_W    = 18
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 l_sem_n,
  input logic                 l_oe_n,
  input logic                 r_sem_n,
  input logic                 r_oe_n,
  input logic                 l_wd0,
  input logic                 r_wd0,
  input logic [DATA_W-1:0]    l_rdata,
  input logic [DATA_W-1:0]    r_rdata,
  input logic [NUM_FLAGS-1:0] lwr_vec,
  input logic [NUM_FLAGS-1:0] rwr_vec,
  input logic [NUM_FLAGS-1:0] own_l_vec,
  input logic [NUM_FLAGS-1:0] own_r_vec,
  input logic [NUM_FLAGS-1:0] req_l_vec,
  input logic [NUM_FLAGS-1:0] req_r_vec
);

  logic l_rd, r_rd;
  assign l_rd = ~l_sem_n & ~l_oe_n;
  assign r_rd = ~r_sem_n & ~r_oe_n;

  AST_L_REPLICATED: assert property (@(posedge clk) disable iff (rst) (l_rdata == '0) || (l_rdata == '1)); // R2
  AST_R_REPLICATED: assert property (@(posedge clk) disable iff (rst) (r_rdata == '0) || (r_rdata == '1)); // R2
  AST_L_READ_HOLD: assert property (@(posedge clk) disable iff (rst) l_rd ##1 l_rd |=> $stable(l_rdata)); // R8
  AST_R_READ_HOLD: assert property (@(posedge clk) disable iff (rst) r_rd ##1 r_rd |=> $stable(r_rdata)); // R8
  AST_L_IDLE_ONES: assert property (@(posedge clk) disable iff (rst) !l_rd |=> (l_rdata == '1)); // R9
  AST_R_IDLE_ONES: assert property (@(posedge clk) disable iff (rst) !r_rd |=> (r_rdata == '1)); // R9
  AST_NO_SELECT_NO_CHANGE: assert property (@(posedge clk) disable iff (rst)
    (l_sem_n && r_sem_n) |=> ($stable(own_l_vec) && $stable(own_r_vec))); // R11

  for (genvar f = 0; f < NUM_FLAGS; f++) begin : g_flag
    AST_OWNER_HAS_REQ_L: assert property (@(posedge clk) disable iff (rst) own_l_vec[f] |-> !req_l_vec[f]); // R4
    AST_OWNER_HAS_REQ_R: assert property (@(posedge clk) disable iff (rst) own_r_vec[f] |-> !req_r_vec[f]); // R4
    AST_KEEP_L: assert property (@(posedge clk) disable iff (rst)
      (own_l_vec[f] && !(lwr_vec[f] && l_wd0)) |=> own_l_vec[f]); // R4
    AST_KEEP_R: assert property (@(posedge clk) disable iff (rst)
      (own_r_vec[f] && !(rwr_vec[f] && r_wd0)) |=> own_r_vec[f]); // R4
    AST_HANDOFF_L2R: assert property (@(posedge clk) disable iff (rst)
      (own_l_vec[f] && lwr_vec[f] && l_wd0 && !req_r_vec[f] && !rwr_vec[f]) |=> own_r_vec[f]); // R5
    AST_HANDOFF_R2L: assert property (@(posedge clk) disable iff (rst)
      (own_r_vec[f] && rwr_vec[f] && r_wd0 && !req_l_vec[f] && !lwr_vec[f]) |=> own_l_vec[f]); // R5
    AST_TIE_ONE_WINNER: assert property (@(posedge clk) disable iff (rst)
      (!own_l_vec[f] && !own_r_vec[f] && lwr_vec[f] && !l_wd0 && rwr_vec[f] && !r_wd0)
      |=> $countones({own_l_vec[f], own_r_vec[f]}) == 1); // R7
  end

endmodule

bind sem_bank2p sem_bank2p_chk #(.NUM_FLAGS(NUM_FLAGS), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst),
  .l_sem_n(l_sem_n), .l_oe_n(l_oe_n), .r_sem_n(r_sem_n), .r_oe_n(r_oe_n),
  .l_wd0(l_wdata[0]), .r_wd0(r_wdata[0]),
  .l_rdata(l_rdata), .r_rdata(r_rdata),
  .lwr_vec(lwr_vec), .rwr_vec(rwr_vec),
  .own_l_vec(own_l_vec), .own_r_vec(own_r_vec),
  .req_l_vec(req_l_vec), .req_r_vec(req_r_vec)
);

// File: tb/test_sem_bank2p.sv
module test_sem_bank2p;
  localparam int CLK_P = 10;
  localparam int AW = 16;
  localparam int DW = 18;
  localparam int NF = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic l_sem_n, l_oe_n, l_wr_n, r_sem_n, r_oe_n, r_wr_n;
  logic [AW-1:0] l_addr, r_addr;
  logic [DW-1:0] l_wdata, r_wdata;
  logic [DW-1:0] lrd1, rrd1, lrd0, rrd0;

  always #(CLK_P/2) clk = ~clk;

  sem_bank2p #(.ADDR_W(AW), .DATA_W(DW), .NUM_FLAGS(NF), .TIE_MODE(1)) i_sem_bank2p (
    .clk(clk), .rst(rst),
    .l_sem_n(l_sem_n), .l_oe_n(l_oe_n), .l_wr_n(l_wr_n), .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(lrd1),
    .r_sem_n(r_sem_n), .r_oe_n(r_oe_n), .r_wr_n(r_wr_n), .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(rrd1)
  );

  sem_bank2p #(.ADDR_W(AW), .DATA_W(DW), .NUM_FLAGS(NF), .TIE_MODE(0)) i_sem_bank2p_fixed (
    .clk(clk), .rst(rst),
    .l_sem_n(l_sem_n), .l_oe_n(l_oe_n), .l_wr_n(l_wr_n), .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(lrd0),
    .r_sem_n(r_sem_n), .r_oe_n(r_oe_n), .r_wr_n(r_wr_n), .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(rrd0)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // model: owner 0 free, 1 left, 2 right; index 0 = fixed-left copy, 1 = alternating copy
  int own_m[2][NF];
  bit reql[NF], reqr[NF];
  bit tie_m;
  bit expl[2], expr[2];
  bit prvl, prvr;

  task automatic cmp(input string tag, input string who, input logic [DW-1:0] act, input bit e);
    n_cmp++;
    if (act !== {DW{e}}) begin
      n_bad++;
      $display("FAIL %s %s rdata actual=%h expected=%h", tag, who, act, {DW{e}});
    end
  endtask

  task automatic step(input string tag);
    bit rdl, rdr, wl, wrr, anytie;
    int fl, fr;
    bit nl[NF], nr[NF];
    rdl = !l_sem_n && !l_oe_n;
    rdr = !r_sem_n && !r_oe_n;
    fl = int'(l_addr[2:0]);
    fr = int'(r_addr[2:0]);
    for (int k = 0; k < 2; k++) begin
      if (!rdl) expl[k] = 1'b1; else if (!prvl) expl[k] = (own_m[k][fl] == 1) ? 1'b0 : 1'b1;
      if (!rdr) expr[k] = 1'b1; else if (!prvr) expr[k] = (own_m[k][fr] == 2) ? 1'b0 : 1'b1;
    end
    prvl = rdl;
    prvr = rdr;
    wl  = !l_sem_n && !l_wr_n;
    wrr = !r_sem_n && !r_wr_n;
    for (int f = 0; f < NF; f++) begin
      nl[f] = (wl && fl == f) ? l_wdata[0] : reql[f];
      nr[f] = (wrr && fr == f) ? r_wdata[0] : reqr[f];
    end
    for (int k = 0; k < 2; k++) begin
      anytie = 1'b0;
      for (int f = 0; f < NF; f++) begin
        case (own_m[k][f])
          0: if (!nl[f] && !nr[f]) begin anytie = 1'b1; own_m[k][f] = (k == 1 && tie_m) ? 2 : 1; end
             else if (!nl[f]) own_m[k][f] = 1;
             else if (!nr[f]) own_m[k][f] = 2;
          1: if (nl[f]) own_m[k][f] = nr[f] ? 0 : 2;
          default: if (nr[f]) own_m[k][f] = nl[f] ? 0 : 1;
        endcase
      end
      if (k == 1 && anytie) tie_m = !tie_m;
    end
    for (int f = 0; f < NF; f++) begin reql[f] = nl[f]; reqr[f] = nr[f]; end
    @(posedge clk);
    @(negedge clk);
    cmp(tag, "left/alt", lrd1, expl[1]);
    cmp(tag, "right/alt", rrd1, expr[1]);
    cmp(tag, "left/fixed", lrd0, expl[0]);
    cmp(tag, "right/fixed", rrd0, expr[0]);
  endtask

  task automatic lx(); l_sem_n = 1; l_oe_n = 1; l_wr_n = 1; l_addr = '0; l_wdata = '1; endtask
  task automatic rx(); r_sem_n = 1; r_oe_n = 1; r_wr_n = 1; r_addr = '0; r_wdata = '1; endtask
  task automatic lw(input logic [AW-1:0] a, input logic [DW-1:0] d);
    l_sem_n = 0; l_oe_n = 1; l_wr_n = 0; l_addr = a; l_wdata = d;
  endtask
  task automatic rw(input logic [AW-1:0] a, input logic [DW-1:0] d);
    r_sem_n = 0; r_oe_n = 1; r_wr_n = 0; r_addr = a; r_wdata = d;
  endtask
  task automatic lr(input logic [AW-1:0] a); l_sem_n = 0; l_oe_n = 0; l_wr_n = 1; l_addr = a; endtask
  task automatic rr(input logic [AW-1:0] a); r_sem_n = 0; r_oe_n = 0; r_wr_n = 1; r_addr = a; endtask

  task automatic peek(input logic [AW-1:0] a, input string tag);
    lr(a); rr(a); step(tag);
    lx(); rx(); step("R9");
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] s;
    lx(); rx();
    for (int k = 0; k < 2; k++) for (int f = 0; f < NF; f++) own_m[k][f] = 0;
    for (int f = 0; f < NF; f++) begin reql[f] = 1; reqr[f] = 1; end
    tie_m = 0; prvl = 0; prvr = 0;
    expl = '{1, 1}; expr = '{1, 1};
    repeat (3) @(negedge clk);
    // R10: outputs during reset are all ones
    cmp("R10", "left/alt", lrd1, 1'b1);
    cmp("R10", "right/fixed", rrd0, 1'b1);
    rst = 1'b0;
    step("R10");
    peek(16'd3, "R10");
    for (int f = 0; f < NF; f++) begin lw(AW'(f), '1); rw(AW'(f), '1); step("R10"); end
    lx(); rx();

    // R4: left takes flag 2, right request cannot steal it
    lw(16'd2, 18'h0); step("R4"); lx();
    peek(16'd2, "R4");
    rw(16'd2, 18'h0); step("R4"); rx();
    peek(16'd2, "R4");
    // R5: release hands the token to the waiting right side
    lw(16'd2, 18'h1); step("R5"); lx();
    peek(16'd2, "R5");
    // R6: waiting left withdraws, then right releases -> free
    lw(16'd2, 18'h0); step("R6");
    lw(16'd2, 18'h1); step("R6"); lx();
    rw(16'd2, 18'h1); step("R6"); rx();
    peek(16'd2, "R6");

    // R7: same-cycle requests, twice, then earlier-wins
    lw(16'd5, 18'h0); rw(16'd5, 18'h0); step("R7"); lx(); rx();
    peek(16'd5, "R7");
    lw(16'd5, 18'h1); step("R7"); lx();
    peek(16'd5, "R7");
    rw(16'd5, 18'h1); step("R7"); rx();
    lw(16'd5, 18'h0); rw(16'd5, 18'h0); step("R7"); lx(); rx();
    peek(16'd5, "R7");
    lw(16'd5, 18'h1); rw(16'd5, 18'h1); step("R7"); lx(); rx();
    lw(16'd6, 18'h0); step("R7"); lx();
    rw(16'd6, 18'h0); step("R7"); rx();
    peek(16'd6, "R7");
    lw(16'd6, 18'h1); rw(16'd6, 18'h1); step("R7"); lx(); rx();
    peek(16'd6, "R7");

    // R1: every flag, upper address bits varied
    for (int f = 0; f < NF; f++) begin
      lw({13'h1ABC ^ 13'(f * 291), 3'(f)}, 18'h0); step("R1"); lx();
      peek({13'(f * 77), 3'(f)}, "R1");
      peek(AW'((f + 1) % NF), "R1");
      lw({13'h0F0F, 3'(f)}, 18'h1); step("R1"); lx();
      peek({13'h1FFF, 3'(f)}, "R1");
    end

    // R3: only bit 0 matters
    lw(16'd4, 18'h3FFFE); step("R3"); lx();
    peek(16'd4, "R3");
    lw(16'd4, 18'h00001); step("R3"); lx();
    peek(16'd4, "R3");

    // R11: write strobe without select changes nothing
    l_sem_n = 1; l_wr_n = 0; l_oe_n = 1; l_addr = 16'd0; l_wdata = '0; step("R11"); lx();
    peek(16'd0, "R11");

    // R8: read held across a hand-off to the reading side
    rw(16'd0, 18'h0); step("R8"); rx();
    lw(16'd0, 18'h0); step("R8");
    lr(16'd0); step("R8");
    rw(16'd0, 18'h1); step("R8"); rx();
    step("R8");
    lx(); step("R9");
    lr(16'd0); step("R8");
    lx(); step("R9");
    lw(16'd0, 18'h1); step("R8"); lx();
    peek(16'd0, "R8");

    // R2: long pseudo-random run over both sides
    s = 32'h1234_5678;
    for (int c = 0; c < 4000; c++) begin
      s ^= s << 13; s ^= s >> 17; s ^= s << 5;
      l_sem_n = s[0] & s[1]; l_oe_n = s[2]; l_wr_n = s[3];
      l_addr = s[19:4]; l_wdata = {s[31:15], s[20]};
      s ^= s << 13; s ^= s >> 17; s ^= s << 5;
      r_sem_n = s[0] & s[1]; r_oe_n = s[2]; r_wr_n = s[3];
      r_addr = s[19:4]; r_wdata = {s[31:15], s[20]};
      step("R2");
    end
    lx(); rx(); step("R9");

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule